// File: doc/BRIEF.md
# Conditional skip sequencer

The sequencer gives a core without branch flags its conditional execution. Certain test instructions raise a skip condition instead of setting a flag: a byte compare, a single-bit test, a compare of a 4-bit pointer nibble, a decrement-and-test-zero, and a return that always skips. When a skip condition is raised, the next instruction is still fetched and stepped over, but its execution is suppressed. Any instruction can be the one that is suppressed.

The decoder presents one instruction per `instr_valid_i` strobe. The strobe carries the test class, the operands the test needs, the instruction's byte length and a flag that marks a direct-addressing prefix. The block answers in the same cycle with `suppress_o`, which the core uses to block every register, memory and branch side effect. It also gives `pc_adv_o`, the number of bytes the fetch pointer moves. A prefix that falls under a skip takes the instruction after it down with it, so the two are suppressed as one unit.

Top module: `skip_seq`

## Requirements
- R1: After reset, whether asynchronous at start-up or mid-run, no skip is pending. The first instruction strobed after reset is not suppressed, and both outputs are 0 while no strobe is present.
- R2: Test class 1 (byte compare) raises a skip when `opa_i` differs from `opb_i`. It raises none when they are equal.
- R3: Test class 2 (bit test) raises a skip when bit `bit_idx_i` of `opa_i` is 0. It raises none when that bit is 1.
- R4: Test class 3 (pointer compare) raises a skip when `bptr_i[3:0]` equals `imm4_i`. Bits above bit 3 of `bptr_i` have no effect on the result.
- R5: Test class 4 (decrement and skip) treats `opa_i` as the register value before the decrement. It raises a skip only when `opa_i` minus 1 is zero modulo 2^8, so `opa_i` = 1 skips and `opa_i` = 0 (which wraps to 0xFF) does not.
- R6: Test class 5 (return and skip) always raises a skip on the next strobed instruction.
- R7: A skip that is not a prefix skip suppresses exactly one instruction. The instruction after it executes.
- R8: A suppressed instruction raises no skip, whatever its test class and operands.
- R9: When the suppressed instruction has `is_prefix_i` = 1, the next strobed instruction is also suppressed. The one after that executes.
- R10: `pc_adv_o` equals `instr_len_i` (1 to 3) on every strobed instruction, suppressed or not, and is 0 when there is no strobe.
- R11: A pending skip is held unchanged through any number of cycles without a strobe. `suppress_o` stays 0 during those cycles.
- R12: Test classes 0, 6 and 7 never raise a skip. An executed prefix raises no skip and no pair suppression.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | One instruction presented this cycle |
| op_i | input | 3 | Test class: 0 plain, 1 byte compare, 2 bit test, 3 pointer compare, 4 decrement-skip, 5 return-skip |
| is_prefix_i | input | 1 | Instruction is a direct-addressing prefix |
| instr_len_i | input | 2 | Instruction length in bytes |
| opa_i | input | 8 | First operand / tested byte / register value before decrement |
| opb_i | input | 8 | Second compare operand |
| bit_idx_i | input | 3 | Bit index for the bit test |
| bptr_i | input | 8 | Pointer register value |
| imm4_i | input | 4 | 4-bit immediate for the pointer compare |
| suppress_o | output | 1 | Presented instruction must not execute |
| pc_adv_o | output | 2 | Byte advance of the fetch pointer |

## Verification
The bench sweeps every operand value of each test class, then plays a long random instruction stream against an arithmetic model. The corners it targets are these:
- Decrement of 0 versus 1: a design with the wrong zero test would skip on the wrap.
- High pointer bits: a design that compared them would miss pointer skips.
- A skip-raising instruction that is itself suppressed: a design that got this wrong would suppress a third instruction in a row.
- Skipped prefix pairs: a design that got these wrong would either let the modified instruction run or swallow the instruction after the pair.
- Idle gaps between strobes: a design that got these wrong would drop the pending skip or assert suppression with no instruction present.

// File: rtl/skip_pkg.sv
package skip_pkg;
  typedef enum logic [2:0] {
    OP_PLAIN    = 3'd0,
    OP_EQ_CMP   = 3'd1,
    OP_BIT_TEST = 3'd2,
    OP_PTR_CMP  = 3'd3,
    OP_DEC_SKZ  = 3'd4,
    OP_RET_SKIP = 3'd5
  } test_op_e;

  typedef enum logic [1:0] {
    SK_IDLE = 2'd0,
    SK_NEXT = 2'd1,
    SK_TAIL = 2'd2
  } skip_st_e;
endpackage

// File: rtl/skip_eval.sv
module skip_eval
  import skip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic [DATA_W-1:0] bptr_i,
  input  logic [NIB_W-1:0]  imm4_i,
  output logic              raise_o
);
  test_op_e op;
  logic [DATA_W-1:0] dec_val;
  logic eq_ne, bit_clr, ptr_hit, dec_zero;

  assign op = test_op_e'(op_i);

  assign eq_ne    = (opa_i != opb_i);
  assign bit_clr  = ~opa_i[bit_idx_i];
  assign ptr_hit  = (bptr_i[NIB_W-1:0] == imm4_i);
  assign dec_val  = opa_i - DATA_W'(1);
  assign dec_zero = (dec_val == '0);

  // upper pointer bits take no part in the compare
  generate
    if (DATA_W > NIB_W) begin : g_hi
      logic unused_ptr_hi;
      assign unused_ptr_hi = ^bptr_i[DATA_W-1:NIB_W];
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_EQ_CMP:   raise_o = eq_ne;
      OP_BIT_TEST: raise_o = bit_clr;
      OP_PTR_CMP:  raise_o = ptr_hit;
      OP_DEC_SKZ:  raise_o = dec_zero;
      OP_RET_SKIP: raise_o = 1'b1;
      default:     raise_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/skip_ctrl.sv
module skip_ctrl
  import skip_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic prefix_i,
  input  logic raise_i,
  output logic suppress_o
);
  skip_st_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    suppress_o = valid_i && (st_q != SK_IDLE);
    if (valid_i) begin
      unique case (st_q)
        SK_NEXT: st_d = prefix_i ? SK_TAIL : SK_IDLE; // prefix drags its target along
        SK_TAIL: st_d = SK_IDLE;
        default: st_d = raise_i ? SK_NEXT : SK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SK_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/pc_step.sv
module pc_step #(
  parameter int LEN_W = 2
) (
  input  logic             valid_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] adv_o
);
  assign adv_o = valid_i ? len_i : '0;
endmodule

// File: rtl/skip_seq.sv
module skip_seq #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4,
  parameter int LEN_W  = 2,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic [2:0]        op_i,
  input  logic              is_prefix_i,
  input  logic [LEN_W-1:0]  instr_len_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic [DATA_W-1:0] bptr_i,
  input  logic [NIB_W-1:0]  imm4_i,
  output logic              suppress_o,
  output logic [LEN_W-1:0]  pc_adv_o
);
  logic raise;

  skip_eval #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_eval (
    .op_i      (op_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .bit_idx_i (bit_idx_i),
    .bptr_i    (bptr_i),
    .imm4_i    (imm4_i),
    .raise_o   (raise)
  );

  skip_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (instr_valid_i),
    .prefix_i   (is_prefix_i),
    .raise_i    (raise),
    .suppress_o (suppress_o)
  );

  pc_step #(.LEN_W(LEN_W)) u_pc (
    .valid_i (instr_valid_i),
    .len_i   (instr_len_i),
    .adv_o   (pc_adv_o)
  );
endmodule

// File: rtl/skip_seq_chk.sv
module skip_seq_chk #(
  parameter int LEN_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             instr_valid_i,
  input logic [2:0]       op_i,
  input logic             is_prefix_i,
  input logic [LEN_W-1:0] instr_len_i,
  input logic             suppress_o,
  input logic [LEN_W-1:0] pc_adv_o
);
  logic       seen_q, prev_pre_q, ret_q;
  logic [1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0; prev_pre_q <= 1'b0; ret_q <= 1'b0; run_q <= 2'd0;
    end else if (instr_valid_i) begin
      seen_q     <= 1'b1;
      prev_pre_q <= is_prefix_i;
      ret_q      <= !suppress_o && (op_i == 3'd5);
      run_q      <= suppress_o ? ((run_q == 2'd2) ? 2'd2 : run_q + 2'd1) : 2'd0;
    end
  end

  AST_FIRST_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && !seen_q) |-> !suppress_o); // R1
  AST_NO_STROBE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |-> (!suppress_o && pc_adv_o == '0)); // R11
  AST_ADV_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i |-> (pc_adv_o == instr_len_i)); // R10
  AST_RET_SKIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && ret_q) |-> suppress_o); // R6
  AST_SINGLE_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && run_q == 2'd1 && !prev_pre_q) |-> !suppress_o); // R7
  AST_PAIR_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && run_q == 2'd1 && prev_pre_q) |-> suppress_o); // R9
  AST_RUN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && run_q == 2'd2) |-> !suppress_o); // R8
endmodule

bind skip_seq skip_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_valid_i (instr_valid_i),
  .op_i          (op_i),
  .is_prefix_i   (is_prefix_i),
  .instr_len_i   (instr_len_i),
  .suppress_o    (suppress_o),
  .pc_adv_o      (pc_adv_o)
);

// File: tb/sim_skip_seq.sv
module sim_skip_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [2:0] op = '0;
  logic       pre = 1'b0;
  logic [1:0] len = 2'd1;
  logic [7:0] a = '0, b = '0, bp = '0;
  logic [2:0] idx = '0;
  logic [3:0] imm = '0;
  logic       sup;
  logic [1:0] adv;

  int n_chk = 0, n_fail = 0;
  int pend = 0; // 0 none, 1 skip next, 2 skip pair tail

  always #4 clk = ~clk;

  skip_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(vld), .op_i(op),
    .is_prefix_i(pre), .instr_len_i(len), .opa_i(a), .opb_i(b),
    .bit_idx_i(idx), .bptr_i(bp), .imm4_i(imm),
    .suppress_o(sup), .pc_adv_o(adv)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit cond(int o, logic [7:0] x, logic [7:0] y,
                              logic [2:0] i, logic [7:0] p, logic [3:0] k);
    case (o)
      1: return x != y;
      2: return x[i] == 1'b0;
      3: return p[3:0] == k;
      4: return x == 8'd1;
      5: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic issue(string tag, int o, bit p, int l, logic [7:0] x,
                       logic [7:0] y, logic [2:0] i, logic [7:0] q, logic [3:0] k);
    bit es;
    @(negedge clk);
    vld = 1'b1; op = 3'(o); pre = p; len = 2'(l); a = x; b = y; idx = i; bp = q; imm = k;
    #1;
    es = (pend != 0);
    chk(tag, int'(sup), int'(es));
    chk("R10", int'(adv), l);
    if (pend == 1)      pend = p ? 2 : 0;
    else if (pend == 2) pend = 0;
    else                pend = cond(o, x, y, i, q, k) ? 1 : 0;
  endtask

  task automatic plain(string tag);
    issue(tag, 0, 1'b0, 1, 8'h00, 8'h00, 3'd0, 8'h00, 4'h0);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    vld = 1'b0; op = 3'd5; pre = 1'b1; len = 2'd3;
    #1;
    chk(tag, int'(sup), 0);
    chk("R10", int'(adv), 0);
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #20;
    idle("R1");
    rst_n = 1'b1;
    idle("R1");
    plain("R1");

    // R2 byte compare: equal and single-bit-different pairs
    for (int x = 0; x < 256; x++) begin
      for (int s = 0; s < 9; s++) begin
        logic [7:0] y;
        y = (s == 8) ? 8'(x) : 8'(x) ^ (8'd1 << s);
        issue("R2", 1, 1'b0, 1, 8'(x), y, 3'd0, 8'h00, 4'h0);
        issue("R2", 0, 1'b0, 2, 8'h00, 8'h00, 3'd0, 8'h00, 4'h0);
        if (pend != 0) plain("R7");
      end
    end
    // R3 bit test: every byte, every bit
    for (int x = 0; x < 256; x++)
      for (int i = 0; i < 8; i++) begin
        issue("R3", 2, 1'b0, 1, 8'(x), 8'h00, 3'(i), 8'h00, 4'h0);
        issue("R3", 0, 1'b0, 3, 8'h00, 8'h00, 3'd0, 8'h00, 4'h0);
      end
    // R4 pointer compare: all pointers, all immediates
    for (int q = 0; q < 256; q++)
      for (int k = 0; k < 16; k++) begin
        issue("R4", 3, 1'b0, 1, 8'h00, 8'h00, 3'd0, 8'(q), 4'(k));
        issue("R4", 0, 1'b0, 1, 8'h00, 8'h00, 3'd0, 8'h00, 4'h0);
      end
    // R5 decrement and skip
    for (int x = 0; x < 256; x++) begin
      issue("R5", 4, 1'b0, 1, 8'(x), 8'h00, 3'd0, 8'h00, 4'h0);
      issue("R5", 0, 1'b0, 1, 8'h00, 8'h00, 3'd0, 8'h00, 4'h0);
    end
    // R12 inert classes, operands chosen so that every test would fire
    for (int o = 6; o < 9; o++) begin
      issue("R12", o % 8, 1'b0, 1, 8'h01, 8'h02, 3'd7, 8'hF3, 4'h3);
      issue("R12", 0, 1'b0, 1, 8'h00, 8'h00, 3'd0, 8'h00, 4'h0);
    end
    // R12 executed prefix, then an equal compare: no pairing, no skip
    issue("R12", 0, 1'b1, 2, 8'h00, 8'h00, 3'd0, 8'h00, 4'h0);
    issue("R12", 1, 1'b0, 1, 8'h55, 8'h55, 3'd0, 8'h00, 4'h0);
    plain("R12");
    // R6 + R9 return-skip over a prefix pair
    issue("R6", 5, 1'b0, 1, 8'h00, 8'h00, 3'd0, 8'h00, 4'h0);
    issue("R6", 0, 1'b1, 2, 8'h00, 8'h00, 3'd0, 8'h00, 4'h0);
    issue("R9", 1, 1'b0, 3, 8'h01, 8'h02, 3'd0, 8'h00, 4'h0);
    plain("R9");
    // R8 suppressed skip-raiser cannot chain
    issue("R8", 1, 1'b0, 1, 8'h01, 8'h02, 3'd0, 8'h00, 4'h0);
    issue("R8", 5, 1'b0, 1, 8'h00, 8'h00, 3'd0, 8'h00, 4'h0);
    plain("R8");
    // R11 pending skip survives idle gaps
    issue("R11", 3, 1'b0, 1, 8'h00, 8'h00, 3'd0, 8'hA7, 4'h7);
    for (int g = 0; g < 5; g++) idle("R11");
    plain("R11");
    plain("R11");
    // R1 mid-run reset clears a pending skip
    issue("R1", 5, 1'b0, 1, 8'h00, 8'h00, 3'd0, 8'h00, 4'h0);
    @(negedge clk); vld = 1'b0; rst_n = 1'b0; pend = 0;
    @(negedge clk); rst_n = 1'b1;
    plain("R1");

    // random stream against the model
    for (int n = 0; n < 20000; n++) begin
      if ($urandom_range(0, 4) == 0) idle("R11");
      else
        issue("R8", int'($urandom_range(0, 7)), ($urandom_range(0, 3) == 0),
              int'($urandom_range(1, 3)), 8'($urandom_range(0, 3)),
              8'($urandom_range(0, 3)), 3'($urandom), 8'($urandom), 4'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule